// File: doc/BRIEF.md
# Delay-Line Wavelength Assignment Scheduler

This block decides, one packet request at a time, where a packet bound for a given output port should go. It goes straight out when that port still has an idle wavelength. Otherwise it is parked on one wavelength of a shared bank of fiber delay lines. If no delay line is long enough, it is dropped. For each buffer wavelength the block keeps a backlog counter in time slots. This counter sets how long the next packet placed on that wavelength has to wait.

An upstream slot buffer presents the requests of one time slot on consecutive clock cycles, in ascending input-port order. A slot tick follows the last request of the slot and ages every backlog by one slot. A run-time mode input picks the buffer wavelength in one of two ways. In cyclic mode it takes the next wavelength after the previous one used. In shortest-backlog mode it takes the wavelength with the smallest counter.

Top module: `dl_wave_sched`

## Requirements
- R1: When the destination port has at least one idle wavelength (`port_free` bit `port*W+w` set), the decision is direct (`dec_kind`=2'b01) and `dec_wl` is the lowest idle wavelength index of that port; no backlog counter changes.
- R2: A packet that is buffered on wavelength w sets that wavelength's backlog to the delay it received plus its length in slots.
- R3: A slot tick lowers every non-zero backlog by one and leaves zero backlogs at zero; a request presented in the same cycle as a tick is served with the backlogs from before that tick.
- R4: With `mode_minq`=0 the buffer wavelength is the one after the last wavelength on which a packet was buffered, wrapping from W-1 to 0; after reset the first choice is wavelength 0.
- R5: With `mode_minq`=1 the buffer wavelength is the one with the smallest backlog, the lowest index winning ties.
- R6: Requests are served strictly in presentation order, and each request sees the backlog left by all requests before it.
- R7: A buffered decision (`dec_kind`=2'b10) reports `dec_line` equal to the chosen wavelength's backlog, or 1 when that backlog is zero.
- R8: When the delay required on the chosen wavelength exceeds B, the decision is drop (`dec_kind`=2'b11), and neither the backlog nor the cyclic pointer changes; a delay of exactly B is still buffered.
- R9: After reset `dec_valid` is 0 and all backlogs are zero.
- R10: Each request yields exactly one decision, with `dec_valid` high for one cycle in the clock cycle after the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_minq | input | 1 | 0: cyclic wavelength choice, 1: shortest-backlog choice |
| slot_tick | input | 1 | End of time slot; ages all backlogs by one |
| req_valid | input | 1 | A packet request is presented this cycle |
| req_port | input | 2 | Destination output port |
| req_len | input | 6 | Packet length in slots (1 to 63) |
| port_free | input | 16 | Idle flags, bit `port*W+w` for wavelength w of port `port` |
| dec_valid | output | 1 | Decision present |
| dec_kind | output | 2 | 01 direct, 10 buffered, 11 dropped |
| dec_wl | output | 2 | Chosen output or buffer wavelength |
| dec_line | output | 4 | Delay-line index (slots of delay), 0 unless buffered |

## Verification
The assertions take for granted that the packet length on a request is never zero. They also assume that `req_port` names an existing port, and that `port_free` and `mode_minq` are steady while a request is presented. The bench drives every request for exactly one cycle with a length between 1 and 63 and only valid port numbers. It changes the mode and the idle flags only between requests. It asserts the slot tick alone, except in the one scenario that checks tick-and-request ordering on purpose.

// File: rtl/dl_wave_sched_pkg.sv
package dl_wave_sched_pkg;
   typedef enum logic [1:0] {
      KIND_NONE   = 2'b00,
      KIND_DIRECT = 2'b01,
      KIND_BUF    = 2'b10,
      KIND_DROP   = 2'b11
   } dec_kind_e;
endpackage

// File: rtl/dl_backlog_bank.sv
module dl_backlog_bank #(
   parameter int W  = 4,
   parameter int CW = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick,
   input  logic [W-1:0]          ld_en,
   input  logic [CW-1:0]         ld_val,
   output logic [W-1:0][CW-1:0]  cnt
);
   localparam logic [CW-1:0] ONE = CW'(1);

   for (genvar g = 0; g < W; g++) begin : g_wl
      logic [CW-1:0] base;
      always_comb begin
         base = ld_en[g] ? ld_val : cnt[g];
      end

      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt[g] <= '0;
         else if (tick && base != '0)
            cnt[g] <= base - ONE;
         else
            cnt[g] <= base;
      end

      // R3: idle wavelength ages by exactly one slot per tick
      p_dec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (tick && !ld_en[g] && cnt[g] != '0) |=> cnt[g] == $past(cnt[g]) - ONE);
      // R3: an empty backlog stays empty on a tick
      p_dec_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (tick && !ld_en[g] && cnt[g] == '0) |=> cnt[g] == '0);
      // R2: a backlog only changes on a load or a tick
      p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (!tick && !ld_en[g]) |=> $stable(cnt[g]));
   end
endmodule

// File: rtl/dl_wave_pick.sv
module dl_wave_pick #(
   parameter int W  = 4,
   parameter int CW = 7,
   localparam int WW = (W > 1) ? $clog2(W) : 1
) (
   input  logic                  mode_minq,
   input  logic [WW-1:0]         last_wl,
   input  logic [W-1:0][CW-1:0]  cnt,
   output logic [WW-1:0]         sel_wl
);
   localparam logic [WW-1:0] TOP = WW'(W - 1);

   logic [WW-1:0] rr_wl;
   logic [WW-1:0] min_wl;
   logic [CW-1:0] min_val;

   always_comb begin
      rr_wl = (last_wl == TOP) ? '0 : last_wl + WW'(1);
   end

   always_comb begin
      min_wl  = '0;
      min_val = cnt[0];
      for (int i = 1; i < W; i++) begin
         if (cnt[i] < min_val) begin
            min_val = cnt[i];
            min_wl  = WW'(i);
         end
      end
   end

   always_comb begin
      sel_wl = mode_minq ? min_wl : rr_wl;
   end
endmodule

// File: rtl/dl_free_find.sv
module dl_free_find #(
   parameter int W = 4,
   localparam int WW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  free_vec,
   output logic          any_free,
   output logic [WW-1:0] free_wl
);
   always_comb begin
      any_free = |free_vec;
      free_wl  = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (free_vec[i]) free_wl = WW'(i);
      end
   end
endmodule

// File: rtl/dl_wave_sched.sv
module dl_wave_sched
   import dl_wave_sched_pkg::*;
#(
   parameter int N  = 4,
   parameter int W  = 4,
   parameter int B  = 8,
   parameter int LW = 6,
   localparam int PW  = (N > 1) ? $clog2(N) : 1,
   localparam int WW  = (W > 1) ? $clog2(W) : 1,
   localparam int LNW = $clog2(B + 1),
   localparam int CW  = $clog2(B + (1 << LW) + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_minq,
   input  logic             slot_tick,
   input  logic             req_valid,
   input  logic [PW-1:0]    req_port,
   input  logic [LW-1:0]    req_len,
   input  logic [N*W-1:0]   port_free,
   output logic             dec_valid,
   output logic [1:0]       dec_kind,
   output logic [WW-1:0]    dec_wl,
   output logic [LNW-1:0]   dec_line
);
   if (N < 1) begin : g_bad_n
      $error("dl_wave_sched: N must be at least 1");
   end
   if (W < 2) begin : g_bad_w
      $error("dl_wave_sched: W must be at least 2");
   end
   if (B < 1) begin : g_bad_b
      $error("dl_wave_sched: B must be at least 1");
   end
   if (LW < 1) begin : g_bad_lw
      $error("dl_wave_sched: LW must be at least 1");
   end

   localparam logic [CW-1:0] DEPTH = CW'(B);
   localparam logic [CW-1:0] ONE   = CW'(1);

   logic [W-1:0][CW-1:0] cnt;
   logic [W-1:0]         free_vec;
   logic                 any_free;
   logic [WW-1:0]        free_wl;
   logic [WW-1:0]        last_wl;
   logic [WW-1:0]        sel_wl;
   logic [CW-1:0]        q_len;
   logic [CW-1:0]        need;
   logic                 fits;
   logic                 accept;
   logic [W-1:0]         ld_en;
   logic [CW-1:0]        ld_val;

   always_comb begin
      free_vec = port_free[req_port * W +: W];
   end

   dl_free_find #(.W(W)) u_free (
      .free_vec (free_vec),
      .any_free (any_free),
      .free_wl  (free_wl)
   );

   dl_wave_pick #(.W(W), .CW(CW)) u_pick (
      .mode_minq (mode_minq),
      .last_wl   (last_wl),
      .cnt       (cnt),
      .sel_wl    (sel_wl)
   );

   always_comb begin
      q_len  = cnt[sel_wl];
      need   = (q_len == '0) ? ONE : q_len;
      fits   = (need <= DEPTH);
      accept = req_valid && !any_free && fits;
      ld_val = need + CW'(req_len);
      ld_en  = '0;
      if (accept) ld_en[sel_wl] = 1'b1;
   end

   dl_backlog_bank #(.W(W), .CW(CW)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (slot_tick),
      .ld_en  (ld_en),
      .ld_val (ld_val),
      .cnt    (cnt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         last_wl <= WW'(W - 1);
      else if (accept)
         last_wl <= sel_wl;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid <= 1'b0;
         dec_kind  <= KIND_NONE;
         dec_wl    <= '0;
         dec_line  <= '0;
      end else begin
         dec_valid <= req_valid;
         if (!req_valid) begin
            dec_kind <= KIND_NONE;
            dec_wl   <= '0;
            dec_line <= '0;
         end else if (any_free) begin
            dec_kind <= KIND_DIRECT;
            dec_wl   <= free_wl;
            dec_line <= '0;
         end else if (fits) begin
            dec_kind <= KIND_BUF;
            dec_wl   <= sel_wl;
            dec_line <= LNW'(need);
         end else begin
            dec_kind <= KIND_DROP;
            dec_wl   <= sel_wl;
            dec_line <= '0;
         end
      end
   end

   // R1: an idle wavelength on the destination port always gives a direct decision
   p_direct_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && port_free[req_port * W +: W] != '0) |=> dec_kind == KIND_DIRECT);
   // R7: a buffered packet uses an existing delay line
   p_line_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_kind == KIND_BUF) |-> (dec_line >= LNW'(1) && 32'(dec_line) <= B));
   // R8: a drop never touches any backlog
   p_drop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !any_free && !fits) |-> ld_en == '0);
   // R10: every request yields a decision in the next cycle
   p_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> dec_valid);
   // R10: no decision without a request
   p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !dec_valid);
   // R6: at most one wavelength is loaded per request
   p_one_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ld_en));
endmodule

// File: tb/sim_dl_wave_sched.sv
module sim_dl_wave_sched;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_minq = 1'b0;
   logic        slot_tick = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_port = '0;
   logic [5:0]  req_len = '0;
   logic [15:0] port_free = '0;
   logic        dec_valid;
   logic [1:0]  dec_kind;
   logic [1:0]  dec_wl;
   logic [3:0]  dec_line;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dl_wave_sched u0 (
      .clk(clk), .rst_n(rst_n), .mode_minq(mode_minq), .slot_tick(slot_tick),
      .req_valid(req_valid), .req_port(req_port), .req_len(req_len),
      .port_free(port_free), .dec_valid(dec_valid), .dec_kind(dec_kind),
      .dec_wl(dec_wl), .dec_line(dec_line)
   );

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // one request for one cycle; decision sampled at the following negedge
   task automatic send(input int port, input int len, input logic [15:0] fr,
                       input bit tick, input string req,
                       input int kind, input int wl, input int line);
      @(negedge clk);
      req_valid = 1'b1; req_port = 2'(port); req_len = 6'(len);
      port_free = fr; slot_tick = tick;
      @(negedge clk);
      req_valid = 1'b0; slot_tick = 1'b0; port_free = '0;
      check({req, " valid"}, int'(dec_valid), 1);
      check({req, " kind"}, int'(dec_kind), kind);
      check({req, " wl"}, int'(dec_wl), wl);
      check({req, " line"}, int'(dec_line), line);
   endtask

   task automatic tick_n(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); slot_tick = 1'b1;
         @(negedge clk); slot_tick = 1'b0;
      end
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check("R9 valid at reset", int'(dec_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 valid after reset", int'(dec_valid), 0);
   endtask

   task automatic t_direct();
      // port 2 has wavelengths 1 and 3 idle: bits 9 and 11
      send(2, 5, 16'h0A00, 1'b0, "R1 direct", 1, 1, 0);
      @(negedge clk);
      check("R10 single pulse", int'(dec_valid), 0);
   endtask

   task automatic t_cyclic();
      mode_minq = 1'b0;
      send(0, 3, '0, 1'b0, "R4 first wl0", 2, 0, 1); // R1 untouched: line 1
      send(1, 2, '0, 1'b0, "R4 wl1", 2, 1, 1);
      send(2, 5, '0, 1'b0, "R4 wl2", 2, 2, 1);
      send(3, 1, '0, 1'b0, "R4 wl3", 2, 3, 1);
      send(0, 2, '0, 1'b0, "R2 R4 wrap wl0", 2, 0, 4);   // backlogs 6,3,6,2
   endtask

   task automatic t_tick_minq();
      tick_n(3);                                           // 3,0,3,0
      mode_minq = 1'b1;
      send(1, 1, '0, 1'b0, "R3 R5 tie low", 2, 1, 1);    // 3,2,3,0
      send(1, 1, '0, 1'b0, "R5 min wl3", 2, 3, 1);       // 3,2,3,2
      send(2, 4, '0, 1'b0, "R6 R5 tie wl1", 2, 1, 2);    // 3,6,3,2
      send(2, 1, '0, 1'b0, "R6 min wl3", 2, 3, 2);       // 3,6,3,3
      send(0, 6, '0, 1'b0, "R7 tie wl0", 2, 0, 3);       // 9,6,3,3
   endtask

   task automatic t_drop();
      mode_minq = 1'b0;                                    // last wl0
      send(1, 4, '0, 1'b0, "R4 wl1", 2, 1, 6);           // 9,10,3,3
      send(1, 2, '0, 1'b0, "R4 wl2", 2, 2, 3);           // 9,10,5,3
      send(1, 1, '0, 1'b0, "R4 wl3", 2, 3, 3);           // 9,10,5,4
      send(1, 1, '0, 1'b0, "R8 drop wl0", 3, 0, 0);
      send(1, 1, '0, 1'b0, "R8 pointer held", 3, 0, 0);
      tick_n(1);                                           // 8,9,4,3
      send(1, 1, '0, 1'b0, "R8 depth edge", 2, 0, 8);    // 9,9,4,3
      send(1, 1, '0, 1'b0, "R8 drop wl1", 3, 1, 0);
   endtask

   task automatic t_same_cycle();
      mode_minq = 1'b1;
      send(3, 2, '0, 1'b1, "R3 served before tick", 2, 3, 3); // 8,8,3,4
      send(3, 1, '0, 1'b0, "R3 tick after", 2, 2, 3);
   endtask

   initial begin
      t_reset();
      t_direct();
      t_cyclic();
      t_tick_minq();
      t_drop();
      t_same_cycle();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule